// File: doc/BRIEF.md
# DMA Channel Address Register Bank

This block holds the source and destination address registers of a four-channel DMA controller. Software reaches it over a simple memory-mapped bus with one request per cycle and a single-cycle accept. The bus offset is taken relative to the controller's base address. Each channel owns a 16-byte group. Its source address sits at offset 0x100 + 16·ch and its destination address at offset 0x104 + 16·ch. Only full 32-bit writes are taken. A byte or halfword write is refused with a bus error.

The upper twelve bits of every address must name one of four permitted memory regions: 0x000, 0x1FF, 0x200 or 0x400. A write with any other upper value is still stored and draws no bus error. The fault is deferred until the channel is started. On a per-channel start pulse, the bank checks both addresses of that channel for a permitted region and for alignment to the channel's source and destination transfer sizes. Any failure sets a sticky configuration error bit for that channel. The bit stays set until a per-channel clear input removes it. The transfer engine reads the addresses and error bits from the output ports.

Top module: `dma_addr_bank`

## Requirements
- R1: After a synchronous active-low reset, every source and destination address is zero, every configuration error bit is zero, and bus_ack and bus_err are low.
- R2: A write request with bus_size=2 (word) to offset 0x100+16·ch loads the source address of channel ch, and to 0x104+16·ch loads its destination address. The new value appears on src_addr/dst_addr (channel ch in bits 32·ch+31..32·ch) in the cycle after the request. A later read returns it, with bits 31..20 exactly as written when they hold a permitted region.
- R3: A write request with bus_size=0 (byte) or bus_size=1 (halfword), to any offset, is answered with bus_err high together with bus_ack, and it changes no register.
- R4: Every request held for one cycle on bus_valid is answered by bus_ack high for exactly the following cycle. Read data is presented on bus_rdata in that same cycle, and bus_err is never high without bus_ack.
- R5: A read of an unmapped offset returns zero with no bus error. A word write to an unmapped offset changes no register and raises no bus error.
- R6: A word write whose bits 31..20 are not one of 0x000, 0x1FF, 0x200, 0x400 is stored and answered without bus error. Its bits 19..0 read back as written.
- R7: When ch_start[ch] is high, cfg_err[ch] is set in the next cycle if bits 31..20 of the channel's source or destination address lie outside the permitted regions.
- R8: Size codes per channel (src_size/dst_size bits 2·ch+1..2·ch) are 0 for byte, 1 for halfword, 2 for word and 3 reserved. A start sets cfg_err[ch] if the source or destination address is misaligned for its size (bit 0 set for halfword, bits 1..0 nonzero for word), or if either size code is 3.
- R9: cfg_err[ch] is sticky. A start with a clean configuration leaves it unchanged. cfg_err_clr[ch] clears it in the next cycle, but a failing start in the same cycle as the clear wins and leaves it set.
- R10: Writes, starts and clears on one channel leave the registers and the error bit of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request, one cycle per request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Byte offset from the controller base |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Request accepted, one cycle after bus_valid |
| bus_err | output | 1 | Error response, only with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| ch_start | input | 4 | Per-channel start pulse |
| cfg_err_clr | input | 4 | Per-channel clear of the configuration error |
| src_size | input | 8 | Per-channel source size code, 2 bits each |
| dst_size | input | 8 | Per-channel destination size code, 2 bits each |
| src_addr | output | 128 | Per-channel source address, 32 bits each |
| dst_addr | output | 128 | Per-channel destination address, 32 bits each |
| cfg_err | output | 4 | Per-channel sticky configuration error |

## Verification
A stored address that is wrong shows on src_addr/dst_addr one cycle after the offending write, and on bus_rdata one cycle after the next read of that offset. A decode fault that hits the wrong channel shows at the same point, as a change on another channel's output. A wrong region or alignment evaluation stays hidden until the next start of that channel. It then shows on cfg_err one cycle after the start. Clear-versus-start priority is only visible when both pulses land in the same cycle, so those coincidences are driven on purpose and also arise under random stimulus.

// File: rtl/dma_bank_pkg.sv
// dma_bank_pkg
// Shared types and checks for the DMA address register bank.
// Assumes 32-bit addresses whose bits 31..20 select a memory region.
package dma_bank_pkg;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_HALF = 2'd1,
        XFER_WORD = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_size_e;

    localparam int ADDR_BITS   = 32;
    localparam int REGION_LSB  = 20;
    localparam int REGION_BITS = ADDR_BITS - REGION_LSB;

    // True when the upper field names one of the permitted regions.
    function automatic logic region_permitted(input logic [ADDR_BITS-1:0] a);
        logic [REGION_BITS-1:0] hi;
        hi = a[ADDR_BITS-1:REGION_LSB];
        return (hi == 12'h000) || (hi == 12'h1FF) ||
               (hi == 12'h200) || (hi == 12'h400);
    endfunction

    // True when the address is aligned to the given transfer size.
    function automatic logic size_aligned(input logic [ADDR_BITS-1:0] a,
                                          input logic [1:0] sz);
        logic ok;
        case (xfer_size_e'(sz))
            XFER_BYTE: ok = 1'b1;
            XFER_HALF: ok = (a[0] == 1'b0);
            XFER_WORD: ok = (a[1:0] == 2'b00);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dma_bus_decode.sv
// dma_bus_decode
// Decodes a bus offset into one-hot source and destination register hits.
// Assumes each channel group sits at GROUP_BASE + STRIDE*ch, with the
// source register at +0 and the destination register at +4.
module dma_bus_decode #(
    parameter int NUM_CH     = 4,
    parameter int OFS_W      = 12,
    parameter int GROUP_BASE = 'h100,
    parameter int STRIDE     = 16,
    parameter int DST_OFS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  ofs,
    output logic [NUM_CH-1:0] src_hit,
    output logic [NUM_CH-1:0] dst_hit,
    output logic              any_hit
);

    // Per-channel offset compare.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        localparam logic [OFS_W-1:0] SRC_AT = OFS_W'(GROUP_BASE + STRIDE * c);
        localparam logic [OFS_W-1:0] DST_AT = OFS_W'(GROUP_BASE + STRIDE * c + DST_OFS);
        assign src_hit[c] = (ofs == SRC_AT);
        assign dst_hit[c] = (ofs == DST_AT);
    end

    // Combined hit for unmapped detection.
    assign any_hit = |{src_hit, dst_hit};

    // At most one register is selected per offset.
    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_hit, dst_hit}));

endmodule

// File: rtl/dma_addr_reg.sv
// dma_addr_reg
// One 32-bit address register with a word-write enable.
// Assumes the enable is only raised for accepted full-word writes.
module dma_addr_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    // Storage, cleared on reset and loaded on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

    // Without a write the register holds its value.
    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    // An accepted write lands in the next cycle.
    assert_load_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));

endmodule

// File: rtl/dma_cfg_check.sv
// dma_cfg_check
// Per-channel sticky configuration error, evaluated on a start pulse.
// Assumes the addresses and size codes are stable in the start cycle.
module dma_cfg_check
    import dma_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 clr,
    input  logic [ADDR_BITS-1:0] src,
    input  logic [ADDR_BITS-1:0] dst,
    input  logic [1:0]           src_sz,
    input  logic [1:0]           dst_sz,
    output logic                 err
);

    logic region_bad;
    logic align_bad;
    logic fault;

    // Region and alignment evaluation of the current programming.
    always_comb begin
        region_bad = !region_permitted(src) || !region_permitted(dst);
        align_bad  = !size_aligned(src, src_sz) || !size_aligned(dst, dst_sz);
        fault      = region_bad || align_bad;
    end

    // Sticky error bit: a failing start sets it, ahead of a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (start && fault)
            err <= 1'b1;
        else if (clr)
            err <= 1'b0;
    end

    assert_region_fault_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && region_bad) |=> err);

    assert_align_fault_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && align_bad) |=> err);

    assert_clear_wins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !start) |=> !err);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !clr) |=> $stable(err));

endmodule

// File: rtl/dma_addr_bank.sv
// dma_addr_bank
// Source/destination address registers for a multi-channel DMA controller,
// with size-checked bus writes and a deferred configuration error at start.
// Assumes one-cycle requests on bus_valid; every request is accepted in the
// following cycle. bus_addr is the byte offset from the controller base.
module dma_addr_bank
    import dma_bank_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int OFS_W      = 12,
    parameter int GROUP_BASE = 'h100,
    parameter int STRIDE     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [1:0]                 bus_size,
    input  logic [OFS_W-1:0]           bus_addr,
    input  logic [ADDR_BITS-1:0]       bus_wdata,
    output logic                       bus_ack,
    output logic                       bus_err,
    output logic [ADDR_BITS-1:0]       bus_rdata,
    input  logic [NUM_CH-1:0]          ch_start,
    input  logic [NUM_CH-1:0]          cfg_err_clr,
    input  logic [2*NUM_CH-1:0]        src_size,
    input  logic [2*NUM_CH-1:0]        dst_size,
    output logic [ADDR_BITS*NUM_CH-1:0] src_addr,
    output logic [ADDR_BITS*NUM_CH-1:0] dst_addr,
    output logic [NUM_CH-1:0]          cfg_err
);

    localparam int AW = ADDR_BITS;

    logic [NUM_CH-1:0] src_hit;
    logic [NUM_CH-1:0] dst_hit;
    logic              any_hit;
    logic              full_word;
    logic              wr_ok;
    logic [AW-1:0]     rd_mux;

    dma_bus_decode #(
        .NUM_CH    (NUM_CH),
        .OFS_W     (OFS_W),
        .GROUP_BASE(GROUP_BASE),
        .STRIDE    (STRIDE),
        .DST_OFS   (4)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ofs    (bus_addr),
        .src_hit(src_hit),
        .dst_hit(dst_hit),
        .any_hit(any_hit)
    );

    // Write qualification: only full-word writes reach a register.
    always_comb begin
        full_word = (xfer_size_e'(bus_size) == XFER_WORD);
        wr_ok     = bus_valid && bus_write && full_word;
    end

    // Per-channel register pair and configuration checker.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [AW-1:0] s_q;
        logic [AW-1:0] d_q;

        dma_addr_reg #(.DATA_W(AW)) u_src (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_ok && src_hit[c]),
            .wdata(bus_wdata),
            .q    (s_q)
        );

        dma_addr_reg #(.DATA_W(AW)) u_dst (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_ok && dst_hit[c]),
            .wdata(bus_wdata),
            .q    (d_q)
        );

        dma_cfg_check u_chk (
            .clk   (clk),
            .rst_n (rst_n),
            .start (ch_start[c]),
            .clr   (cfg_err_clr[c]),
            .src   (s_q),
            .dst   (d_q),
            .src_sz(src_size[2*c +: 2]),
            .dst_sz(dst_size[2*c +: 2]),
            .err   (cfg_err[c])
        );

        assign src_addr[AW*c +: AW] = s_q;
        assign dst_addr[AW*c +: AW] = d_q;
    end

    // Read mux: OR of the selected register, zero when unmapped.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (src_hit[c]) rd_mux = rd_mux | src_addr[AW*c +: AW];
            if (dst_hit[c]) rd_mux = rd_mux | dst_addr[AW*c +: AW];
        end
    end

    // Response register: accept, error and read data one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_valid;
            bus_err   <= bus_valid && bus_write && !full_word;
            bus_rdata <= (bus_valid && !bus_write) ? rd_mux : '0;
        end
    end

    assert_ack_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ack);

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ack);

    assert_err_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    assert_narrow_write_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_size != 2'd2)) |=> bus_err);

    assert_unmapped_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !any_hit) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_dma_addr_bank.sv
// sim_dma_addr_bank
// Directed corner cases followed by seeded random traffic, checked against
// a bench-side model of the registers and error bits.
module sim_dma_addr_bank;

    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_valid;
    logic              bus_write;
    logic [1:0]        bus_size;
    logic [11:0]       bus_addr;
    logic [31:0]       bus_wdata;
    logic              bus_ack;
    logic              bus_err;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    ch_start;
    logic [NCH-1:0]    cfg_err_clr;
    logic [2*NCH-1:0]  src_size;
    logic [2*NCH-1:0]  dst_size;
    logic [32*NCH-1:0] src_addr;
    logic [32*NCH-1:0] dst_addr;
    logic [NCH-1:0]    cfg_err;

    always #5 clk = ~clk;

    dma_addr_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_size   (bus_size),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .ch_start   (ch_start),
        .cfg_err_clr(cfg_err_clr),
        .src_size   (src_size),
        .dst_size   (dst_size),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .cfg_err    (cfg_err)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0]    m_src [NCH];
    logic [31:0]    m_dst [NCH];
    logic [NCH-1:0] m_err;

    function automatic bit f_region(input logic [31:0] a);
        return a[31:20] == 12'h000 || a[31:20] == 12'h1FF ||
               a[31:20] == 12'h200 || a[31:20] == 12'h400;
    endfunction

    function automatic bit f_aligned(input logic [31:0] a, input logic [1:0] sz);
        if (sz == 2'd0) return 1'b1;
        if (sz == 2'd1) return a[0] == 1'b0;
        if (sz == 2'd2) return a[1:0] == 2'b00;
        return 1'b0;
    endfunction

    function automatic bit f_fault(input int c);
        return !f_region(m_src[c]) || !f_region(m_dst[c]) ||
               !f_aligned(m_src[c], src_size[2*c +: 2]) ||
               !f_aligned(m_dst[c], dst_size[2*c +: 2]);
    endfunction

    // Returns channel index, or -1 for an unmapped offset.
    function automatic int f_decode(input logic [11:0] ofs, output bit is_dst);
        is_dst = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (ofs == 12'(12'h100 + 16 * c)) return c;
            if (ofs == 12'(12'h104 + 16 * c)) begin is_dst = 1'b1; return c; end
        end
        return -1;
    endfunction

    // Readback mask: upper bits only meaningful for a permitted region.
    function automatic logic [31:0] f_mask(input logic [31:0] a);
        return f_region(a) ? 32'hFFFF_FFFF : 32'h000F_FFFF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compares every channel's outputs against the model (R10 isolation).
    task automatic chk_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] mk;
            mk = f_mask(m_src[c]);
            chk((src_addr[32*c +: 32] & mk) == (m_src[c] & mk), req,
                src_addr[32*c +: 32], m_src[c]);
            mk = f_mask(m_dst[c]);
            chk((dst_addr[32*c +: 32] & mk) == (m_dst[c] & mk), req,
                dst_addr[32*c +: 32], m_dst[c]);
        end
        chk(cfg_err == m_err, req, 32'(cfg_err), 32'(m_err));
    endtask

    task automatic bus_op(input bit wr, input logic [1:0] sz, input logic [11:0] ofs,
                          input logic [31:0] d, output logic [31:0] rd,
                          output bit ack, output bit err);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_size = sz;
        bus_addr = ofs; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        ack = bus_ack; err = bus_err; rd = bus_rdata;
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [11:0] ofs,
                            input logic [31:0] d);
        logic [31:0] rd; bit ack; bit err; bit is_dst; int c;
        bus_op(1'b1, sz, ofs, d, rd, ack, err);
        chk(ack == 1'b1, "R4 write ack", 32'(ack), 1);
        // R3 narrow error, R5/R6 no error for word writes
        chk(err == (sz != 2'd2), "R3/R6 write error response", 32'(err), 32'(sz != 2'd2));
        c = f_decode(ofs, is_dst);
        if (sz == 2'd2 && c >= 0) begin
            if (is_dst) m_dst[c] = d; else m_src[c] = d;
        end
        chk_all("R2/R3/R5/R10 registers after write");
    endtask

    task automatic do_read(input logic [11:0] ofs);
        logic [31:0] rd; logic [31:0] exp; bit ack; bit err; bit is_dst; int c;
        bus_op(1'b0, 2'd2, ofs, 32'h0, rd, ack, err);
        c = f_decode(ofs, is_dst);
        exp = (c < 0) ? 32'h0 : (is_dst ? m_dst[c] : m_src[c]);
        chk(ack == 1'b1 && err == 1'b0, "R4/R5 read response", {30'h0, ack, err}, 32'h2);
        chk((rd & f_mask(exp)) == (exp & f_mask(exp)), "R2/R5/R6 read data", rd, exp);
    endtask

    task automatic do_start(input logic [NCH-1:0] st, input logic [NCH-1:0] cl);
        @(negedge clk);
        ch_start = st; cfg_err_clr = cl;
        for (int c = 0; c < NCH; c++)
            m_err[c] = (st[c] && f_fault(c)) ? 1'b1 : (cl[c] ? 1'b0 : m_err[c]);
        @(negedge clk);
        ch_start = '0; cfg_err_clr = '0;
        chk(cfg_err == m_err, "R7/R8/R9 cfg_err after start/clear", 32'(cfg_err), 32'(m_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
        bus_addr = '0; bus_wdata = '0; ch_start = '0; cfg_err_clr = '0;
        src_size = {NCH{2'd2}}; dst_size = {NCH{2'd2}};
        for (int c = 0; c < NCH; c++) begin m_src[c] = '0; m_dst[c] = '0; end
        m_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(src_addr == '0 && dst_addr == '0, "R1 addresses zero", src_addr[31:0], 0);
        chk(cfg_err == '0, "R1 cfg_err zero", 32'(cfg_err), 0);
        chk(bus_ack == 1'b0 && bus_err == 1'b0, "R1 bus response idle",
            {30'h0, bus_ack, bus_err}, 0);

        // R2 word writes and readback
        do_write(2'd2, 12'h100, 32'h2000_0010);
        do_read(12'h100);
        do_write(2'd2, 12'h134, 32'h1FF0_0004);
        do_read(12'h134);
        // R3 narrow writes refused
        do_write(2'd0, 12'h110, 32'h4000_0000);
        do_write(2'd1, 12'h110, 32'h4000_0000);
        do_read(12'h110);
        // R5 unmapped offsets
        do_read(12'h000);
        do_read(12'h108);
        do_write(2'd2, 12'h10C, 32'h4000_1234);
        do_write(2'd2, 12'h140, 32'h4000_1234);
        // R6 non-permitted region stored, R7 start fault
        do_write(2'd2, 12'h120, 32'h3000_0100);
        do_read(12'h120);
        do_start(4'b0100, 4'b0000);
        do_start(4'b0000, 4'b0100);          // R9 clear
        do_start(4'b0100, 4'b0100);          // R9 failing start beats clear
        do_start(4'b0001, 4'b0000);          // R10 clean start on other channel
        do_write(2'd2, 12'h120, 32'h4000_0100);
        do_start(4'b0100, 4'b0000);          // R9 clean start keeps sticky bit
        do_start(4'b0000, 4'b0100);
        do_start(4'b0100, 4'b0000);
        // R7 destination region fault
        do_write(2'd2, 12'h124, 32'hFFF0_0000);
        do_start(4'b0100, 4'b0100);
        do_write(2'd2, 12'h124, 32'h0000_0000);
        do_start(4'b0000, 4'b0100);
        // R8 alignment and reserved size
        do_write(2'd2, 12'h110, 32'h0000_0002);
        src_size[3:2] = 2'd2; do_start(4'b0010, 4'b0000);
        do_start(4'b0000, 4'b0010);
        src_size[3:2] = 2'd1; do_start(4'b0010, 4'b0000);
        src_size[3:2] = 2'd3; do_start(4'b0010, 4'b0010);
        src_size[3:2] = 2'd0; do_start(4'b0000, 4'b0010);
        do_write(2'd2, 12'h114, 32'h4000_0001);
        dst_size[3:2] = 2'd1; do_start(4'b0010, 4'b0000);
        dst_size[3:2] = 2'd0; do_start(4'b0000, 4'b0010);
        do_start(4'b0010, 4'b0000);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind < 5) begin
                logic [11:0] ofs; logic [31:0] d; logic [1:0] sz; int pick;
                pick = int'($urandom_range(0, 9));
                ofs = (pick < 8) ? 12'(12'h100 + 16 * (pick % 4) + 4 * (pick / 4))
                                 : 12'($urandom_range(0, 12'hFFC) & 12'hFFC);
                d = $urandom;
                case ($urandom_range(0, 4))
                    0: d[31:20] = 12'h000;
                    1: d[31:20] = 12'h1FF;
                    2: d[31:20] = 12'h200;
                    3: d[31:20] = 12'h400;
                    default: ;
                endcase
                if ($urandom_range(0, 1) == 1) d[1:0] = 2'b00;
                sz = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 1)) : 2'd2;
                do_write(sz, ofs, d);
            end else if (kind < 7) begin
                do_read(12'(12'h100 + 4 * $urandom_range(0, 17)));
            end else begin
                src_size = 8'($urandom);
                dst_size = 8'($urandom);
                do_start(4'($urandom), 4'($urandom));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule